// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire open-drain serial bus (clock and data lines, I2C-style framing). It lets a bus master read and write a bank of 16-bit registers that sit behind an 8-bit register pointer. Both lines are brought into the system clock domain and sampled there. The block finds start and stop conditions and compares the first byte of each transaction with its own device address. It then runs a write sequence (pointer byte, then data bytes) or a combined read sequence (pointer write, repeated start, then read). The register file lies outside the block. The block drives a registered write strobe with address and data, and it reads through a combinational read port that is addressed by the current pointer.

Every register moves over the bus as two bytes, high byte first. The pointer steps by one only after both bytes of a word have been transferred. Pointer value 0x80 selects a low-byte alias, so plain byte-wide transfers can split a word access. A lone high byte is held in a staging register. A later byte written to 0x80 commits the full word to the register that was last targeted. Reading a register's high byte latches its low byte, and reading 0x80 afterwards returns that latched byte.

Top module: `twowire_regs`

## Requirements
- R1: A start condition (data falls while clock is high) begins a new transaction from any state. A stop condition (data rises while clock is high) returns the slave to idle with the data line released.
- R2: The first byte after a start is {DEV_ADDR[6:0], dir}, where dir 0 = write and dir 1 = read. On a match, the slave acknowledges by pulling data low during the ninth clock.
- R3: When the address byte does not match, the slave sends no acknowledge, never drives data and performs no register write until the next start.
- R4: In a write, the byte after the address loads the pointer, and every following byte is acknowledged. Each pair of data bytes writes {first, second} to the pointed register. Bits arrive MSB first.
- R5: The pointer increments by one after each complete two-byte word, in both writes and reads. It does not change on a single byte.
- R6: After a pointer write, a repeated start and a read address, the slave sends the high byte and then the low byte of the pointed register, MSB first. A master no-acknowledge ends the read and releases the data line.
- R7: A stop that arrives after only one byte of a word causes no register write.
- R8: A byte written while the pointer is 0x80 writes {staged high byte, that byte} to the register whose high byte was last written. The pointer does not move.
- R9: A byte read while the pointer is 0x80 returns the low byte that was latched by the most recent high-byte read.
- R10: The slave changes its data-line drive only while the synchronized clock is low.
- R11: Every register write is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pulls the data line low (open drain) |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 8 | Register write address |
| reg_wdata | output | 16 | Register write data |
| reg_raddr | output | 8 | Register read address (current pointer) |
| reg_rdata | input | 16 | Register read data, combinational from reg_raddr |

## Verification
The assertions assume a well-behaved master. Such a master changes data only while the clock is low, except when it forms start and stop conditions. It never starts a transaction while the slave holds data low. It also keeps every clock phase several system-clock cycles longer than the synchronizer delay. The bench master meets these conditions: it holds each quarter bit for eight system clocks and moves data one quarter after each clock fall. The bench models the bus as a wired AND of its own drive and the slave's drive, and it keeps the register file at the block's port.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_END, S_RX_ACK, S_TX, S_TX_ACK, S_TX_NEXT, S_IGNORE
  } link_st_t;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rx_kind_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p);
    return p + 8'd1;
  endfunction

  function automatic logic is_alias(input logic [BYTE_W-1:0] p, input logic [BYTE_W-1:0] a);
    return p == a;
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_q, sda_q;
  logic          scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q[0] <= scl_i;
      sda_q[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_q[i] <= scl_q[i-1];
        sda_q[i] <= sda_q[i-1];
      end
      scl_d <= scl_q[LAST];
      sda_d <= sda_q[LAST];
    end
  end

  assign scl_s     = scl_q[LAST];
  assign sda_s     = sda_q[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tw_link.sv
module tw_link
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ev_ptr,
  output logic              ev_wbyte,
  output logic              ev_tx,
  output logic              ev_bus,
  output logic              sda_oe
);
  link_st_t          st;
  rx_kind_t          kind;
  logic              rw;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] sh, txsh;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {sh[BYTE_W-2:0], sda_s};
  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_ADDR;
      rw       <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      txsh     <= '0;
      sda_oe   <= 1'b0;
      ev_ptr   <= 1'b0;
      ev_wbyte <= 1'b0;
      ev_tx    <= 1'b0;
      ev_bus   <= 1'b0;
    end else begin
      ev_ptr   <= 1'b0;
      ev_wbyte <= 1'b0;
      ev_tx    <= 1'b0;
      ev_bus   <= 1'b0;
      if (bus_stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        ev_bus <= 1'b1;
      end else if (bus_start) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        ev_bus <= 1'b1;
      end else begin
        unique case (st)
          S_RX: if (scl_rise) begin
            sh  <= rx_next;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              unique case (kind)
                K_ADDR: begin
                  if (addr_hit(rx_next, DEV_ADDR)) begin
                    rw <= rx_next[0];
                    st <= S_RX_END;
                  end else begin
                    st <= S_IGNORE;
                  end
                end
                K_PTR: begin
                  ev_ptr <= 1'b1;
                  st     <= S_RX_END;
                end
                default: begin
                  ev_wbyte <= 1'b1;
                  st       <= S_RX_END;
                end
              endcase
            end
          end
          S_RX_END: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_RX_ACK;
          end
          S_RX_ACK: if (scl_fall) begin
            cnt <= '0;
            if (kind == K_ADDR && rw) begin
              txsh   <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
              ev_tx  <= 1'b1;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
              st     <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_TX_ACK;
            end else begin
              txsh   <= txsh << 1;
              sda_oe <= ~txsh[BYTE_W-2];
              cnt    <= cnt + 3'd1;
            end
          end
          S_TX_ACK: if (scl_rise) begin
            st <= sda_s ? S_IGNORE : S_TX_NEXT;
          end
          S_TX_NEXT: if (scl_fall) begin
            cnt    <= '0;
            txsh   <= tx_byte;
            sda_oe <= ~tx_byte[BYTE_W-1];
            ev_tx  <= 1'b1;
            st     <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_lowclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (st == S_IDLE && !sda_oe));

  // R3
  quiet_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGNORE) |-> !sda_oe);

endmodule

// File: rtl/tw_pack.sv
module tw_pack
  import tw_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ALIAS_ADDR = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ptr,
  input  logic              ev_wbyte,
  input  logic              ev_tx,
  input  logic              ev_bus,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [WORD_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              we,
  output logic [BYTE_W-1:0] waddr,
  output logic [WORD_W-1:0] wdata
);
  logic [BYTE_W-1:0] ptr, last_tgt, stage_hi, alias_lo;
  logic              phase;
  logic              at_alias;

  assign at_alias = is_alias(ptr, ALIAS_ADDR);
  assign rd_addr  = ptr;
  assign tx_byte  = (at_alias || phase) ? alias_lo : rd_data[WORD_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      last_tgt <= '0;
      stage_hi <= '0;
      alias_lo <= '0;
      phase    <= 1'b0;
      we       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (ev_bus) begin
        phase <= 1'b0;
      end else if (ev_ptr) begin
        ptr   <= rx_byte;
        phase <= 1'b0;
      end else if (ev_wbyte) begin
        if (at_alias) begin
          we    <= 1'b1;
          waddr <= last_tgt;
          wdata <= {stage_hi, rx_byte};
        end else if (!phase) begin
          stage_hi <= rx_byte;
          last_tgt <= ptr;
          phase    <= 1'b1;
        end else begin
          we    <= 1'b1;
          waddr <= ptr;
          wdata <= {stage_hi, rx_byte};
          ptr   <= ptr_step(ptr);
          phase <= 1'b0;
        end
      end else if (ev_tx && !at_alias) begin
        if (!phase) begin
          alias_lo <= rd_data[BYTE_W-1:0];
          phase    <= 1'b1;
        end else begin
          ptr   <= ptr_step(ptr);
          phase <= 1'b0;
        end
      end
    end
  end

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && !$past(ev_ptr)) |-> (ptr == ptr_step($past(ptr))));

endmodule

// File: rtl/twowire_regs.sv
module twowire_regs
  import tw_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h5D,
  parameter logic [BYTE_W-1:0] ALIAS_ADDR  = 8'h80,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_waddr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_raddr,
  input  logic [WORD_W-1:0] reg_rdata
);
  logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              ev_ptr, ev_wbyte, ev_tx, ev_bus;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  tw_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .tx_byte(tx_byte), .rx_byte(rx_byte),
    .ev_ptr(ev_ptr), .ev_wbyte(ev_wbyte), .ev_tx(ev_tx), .ev_bus(ev_bus),
    .sda_oe(sda_oe)
  );

  tw_pack #(.ALIAS_ADDR(ALIAS_ADDR)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .ev_ptr(ev_ptr), .ev_wbyte(ev_wbyte), .ev_tx(ev_tx), .ev_bus(ev_bus),
    .rx_byte(rx_byte), .rd_data(reg_rdata), .rd_addr(reg_raddr),
    .tx_byte(tx_byte), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata)
  );

endmodule

// File: tb/sim_twowire_regs.sv
module sim_twowire_regs;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h5D;
  localparam logic [7:0] AW  = {DEV, 1'b0};
  localparam logic [7:0] AR  = {DEV, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, reg_we;
  logic [7:0] reg_waddr, reg_raddr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] mem [256];
  logic [23:0] exp_q [$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_bus   = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_raddr];

  twowire_regs #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic b_start;
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic b_stop;
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    end
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
    got = !sda_bus;
    qw(); m_scl = 1'b0; qw();
    chk(got == exp_ack, tag, {31'd0, got}, {31'd0, exp_ack});
  endtask

  task automatic recv(input logic [7:0] exp, input bit ack, input string tag);
    logic [7:0] b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); m_scl = 1'b1; qw(); b[i] = sda_bus; qw(); m_scl = 1'b0; qw();
    end
    m_sda = ack ? 1'b0 : 1'b1;
    qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    m_sda = 1'b1;
    chk(b == exp, tag, {24'd0, b}, {24'd0, exp});
  endtask

  // scoreboard monitor: register writes, strobe width, drive timing
  logic prev_oe = 1'b0, prev_we = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != prev_oe)
        chk(m_scl == 1'b0, "R10 drive change with clock low", {31'd0, m_scl}, 32'd0);
      if (reg_we) begin
        chk(!prev_we, "R11 single-cycle strobe", {31'd0, prev_we}, 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R7 unexpected write", {8'd0, reg_waddr, reg_wdata}, 32'd0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({reg_waddr, reg_wdata} == e, "R4/R8 write addr+data",
              {8'd0, reg_waddr, reg_wdata}, {8'd0, e});
        end
        mem[reg_waddr] = reg_wdata;
      end
    end
    prev_oe = sda_oe;
    prev_we = reg_we;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = pat(a[7:0]);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 reset idle", {30'd0, sda_oe, reg_we}, 32'd0);

    // R4 R5: two-word write at 0x10
    exp_q.push_back({8'h10, 16'h1234});
    exp_q.push_back({8'h11, 16'h5678});
    b_start();
    send(AW, 1, "R2 write address ack");
    send(8'h10, 1, "R4 pointer ack");
    send(8'h12, 1, "R4 data ack");
    send(8'h34, 1, "R4 data ack");
    send(8'h56, 1, "R5 data ack");
    send(8'h78, 1, "R5 data ack");
    b_stop();
    chk(exp_q.size() == 0, "R4 both words written", exp_q.size(), 0);
    chk(sda_oe == 1'b0, "R1 released after stop", {31'd0, sda_oe}, 32'd0);

    // R6 R5: combined read back with auto increment
    b_start();
    send(AW, 1, "R6 address ack");
    send(8'h10, 1, "R6 pointer ack");
    b_start();
    send(AR, 1, "R2 read address ack");
    recv(8'h12, 1, "R6 high byte");
    recv(8'h34, 1, "R6 low byte");
    recv(8'h56, 1, "R5 next word high");
    recv(8'h78, 0, "R5 next word low");
    chk(sda_oe == 1'b0, "R6 released after nack", {31'd0, sda_oe}, 32'd0);
    b_stop();

    // R3: foreign address ignored until next start
    b_start();
    send(8'hA0, 0, "R3 no ack foreign address");
    send(8'h40, 0, "R3 no ack while ignoring");
    send(8'h99, 0, "R3 no ack while ignoring");
    b_stop();

    // R7: half word dropped
    b_start();
    send(AW, 1, "R1 recovery after ignore");
    send(8'h20, 1, "R7 pointer ack");
    send(8'hAB, 1, "R7 lone high byte ack");
    b_stop();
    repeat (20) @(negedge clk);
    chk(mem[8'h20] == pat(8'h20), "R7 no write for half word", {16'd0, mem[8'h20]}, {16'd0, pat(8'h20)});

    // R8: alias write commits staged word
    exp_q.push_back({8'h20, 16'hABCD});
    b_start();
    send(AW, 1, "R8 address ack");
    send(8'h80, 1, "R8 alias pointer ack");
    send(8'hCD, 1, "R8 alias byte ack");
    b_stop();
    chk(exp_q.size() == 0, "R8 alias write seen", exp_q.size(), 0);

    // R9: byte read of high, then alias read of low
    b_start();
    send(AW, 1, "R9 address ack");
    send(8'h20, 1, "R9 pointer ack");
    b_start();
    send(AR, 1, "R9 read address ack");
    recv(8'hAB, 0, "R9 high byte alone");
    b_stop();
    b_start();
    send(AW, 1, "R9 address ack");
    send(8'h80, 1, "R9 alias pointer ack");
    b_start();
    send(AR, 1, "R9 read address ack");
    recv(8'hCD, 0, "R9 alias returns latched low");
    b_stop();

    // R6 R5: preset pattern read across word boundary
    b_start();
    send(AW, 1, "R6 address ack");
    send(8'h30, 1, "R6 pointer ack");
    b_start();
    send(AR, 1, "R6 read address ack");
    recv(pat(8'h30) >> 8, 1, "R6 pattern high");
    recv(pat(8'h30) & 16'hFF, 1, "R6 pattern low");
    recv(pat(8'h31) >> 8, 0, "R5 pattern next high");
    b_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule